// File: doc/BRIEF.md
# Cascaded Two-Unit Priority Interrupt Controller

This block merges sixteen interrupt request pins into one interrupt line toward a processor, using two eight-input controller units. The secondary unit's combined request drives input 2 of the primary unit. That input therefore carries no external source, which leaves fifteen usable lines. Software sets up each unit with a short sequence of command bytes, masks lines, and sends end-of-interrupt commands over a byte-wide register port. It chooses edge or level triggering per line through two trigger-select registers.

When the processor pulses its acknowledge, the block picks the highest-priority unmasked request across both units. It marks that request as in service and, one cycle later, returns an 8-bit vector for it. While a request is in service, that unit holds back requests of equal or lower priority until an end-of-interrupt command clears it.

Top module: `pic_cascade_top`

## Requirements
- R1: The effective priority from highest to lowest is line 0, 1, 8, 9, 10, 11, 12, 13, 14, 15, 3, 4, 5, 6, 7. An acknowledge serves the highest-priority unmasked request. Pin `irq_in[2]` has no effect on any output.
- R2: The returned vector is the programmed vector base of the winning unit plus the input's index within that unit (0 to 7). Each unit has its own base.
- R3: A command-port byte with bit 4 set starts initialization. It clears in-service bits and latched requests and sets the mask to 0xFF. The next data-port writes are then taken in order: the vector base; a cascade byte, skipped when bit 1 of the start byte is set; and a mode byte, expected only when bit 0 of the start byte is set. Reset behaves like a start byte of 0x11.
- R4: After initialization, a data-port write loads the unit's mask, where a 1 disables that input. A data-port read returns the mask.
- R5: An edge-triggered line (trigger bit 0) latches a request on a rising edge. The request stays latched after the pin falls and is cleared by its acknowledge. A pin held high does not request again.
- R6: A level-triggered line (trigger bit 1) requests only while its pin is high. A pin that falls before acknowledge leaves no request behind.
- R7: An acknowledge (`int_ack` high for one cycle) returns the vector on `vec_out` with `vec_valid` high in the next cycle. It sets the winner's in-service bit and clears its request. When the winner is on the secondary unit, the secondary bit and primary bit 2 are both set.
- R8: `cpu_irq` is registered. It goes high one cycle after the primary unit has an unmasked request of higher priority than all of its in-service bits, where the secondary unit gates its own output by the same rule.
- R9: Writing 0x20 to a unit's command port clears that unit's highest-priority in-service bit.
- R10: A command-port read returns the request register. After writing 0x0B to that command port it returns the in-service register, and after 0x0A it returns the request register again. Read data appears on `bus_rdata` the cycle after `bus_rd`.
- R11: An acknowledge with no qualifying request returns primary base + 7 and changes no in-service bit.
- R12: Address map: 0 primary command, 1 primary data, 2 secondary command, 3 secondary data, 4 primary trigger select, 5 secondary trigger select. Both trigger-select registers read back as written and reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| irq_in | input | 16 | Request pins, bit 2 unused |
| cpu_irq | output | 1 | Interrupt to processor |
| int_ack | input | 1 | Acknowledge pulse |
| vec_valid | output | 1 | Vector valid, one cycle after acknowledge |
| vec_out | output | 8 | Interrupt vector |

## Verification
Directed sequences cover each trigger mode on its own. A masked edge that is latched and then unmasked separates latching from masking. A level pulse that drops before acknowledge must give the spurious vector, which shows that level requests are not latched. Nested acknowledges of lines 5, 3 and 6 check the in-service blocking and the order in which end-of-interrupt commands take effect. A cascade case puts line 9 against line 4, and a re-initialization in single mode with a new base shows that the cascade byte is skipped and that in-service state is cleared. Random level-triggered request sets and random masks on both units, including the ignored pin 2, are then checked against a bench function that walks the fifteen-line priority order.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {ST_BASE, ST_CASC, ST_MODE, ST_RUN} init_st_t;
  localparam logic [2:0] EOI_NONSPEC = 3'b001;
endpackage

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  bits_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (bits_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/pic_unit.sv
module pic_unit
  import pic_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_wr,
  input  logic          data_wr,
  input  logic [DW-1:0] wdata,
  input  logic [N-1:0]  level_sel,
  input  logic [N-1:0]  req_in,
  input  logic          ack,
  output logic          int_out,
  output logic [IW-1:0] win_idx,
  output logic [DW-1:0] vec_base,
  output logic [N-1:0]  mask_q,
  output logic [N-1:0]  irr_view,
  output logic [N-1:0]  isr_q,
  output logic          read_isr
);
  init_st_t      st;
  logic          need_mode, single;
  logic [N-1:0]  req_prev, edge_lat, pend, clr_top, win_oh;
  logic          pend_any, isr_any, take;
  logic [IW-1:0] isr_idx;
  logic          init_cmd, eoi_cmd, rd_sel_cmd;

  assign irr_view = (edge_lat & ~level_sel) | (req_in & level_sel);
  assign pend     = irr_view & ~mask_q;

  pic_prio_enc #(.N(N), .IW(IW)) u_pend_enc (.bits_i(pend),  .any_o(pend_any), .idx_o(win_idx));
  pic_prio_enc #(.N(N), .IW(IW)) u_isr_enc  (.bits_i(isr_q), .any_o(isr_any),  .idx_o(isr_idx));

  assign int_out    = pend_any && (!isr_any || (win_idx < isr_idx));
  assign take       = ack && int_out;
  assign init_cmd   = cmd_wr && wdata[4];
  assign eoi_cmd    = cmd_wr && !wdata[4] && !wdata[3] && (wdata[7:5] == EOI_NONSPEC);
  assign rd_sel_cmd = cmd_wr && !wdata[4] && wdata[3] && wdata[1];

  always_comb begin
    clr_top = '0;
    if (eoi_cmd && isr_any) clr_top[isr_idx] = 1'b1;
    win_oh = '0;
    win_oh[win_idx] = take;
  end

  always_ff @(posedge clk) req_prev <= req_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_BASE;
      need_mode <= 1'b1;
      single    <= 1'b0;
      mask_q    <= '1;
      isr_q     <= '0;
      edge_lat  <= '0;
      read_isr  <= 1'b0;
      vec_base  <= '0;
    end else if (init_cmd) begin
      st        <= ST_BASE;
      need_mode <= wdata[0];
      single    <= wdata[1];
      mask_q    <= '1;
      isr_q     <= '0;
      edge_lat  <= '0;
      read_isr  <= 1'b0;
    end else begin
      edge_lat <= (edge_lat | (req_in & ~req_prev)) & ~level_sel & ~win_oh;
      isr_q    <= (isr_q & ~clr_top) | win_oh;
      if (rd_sel_cmd) read_isr <= wdata[0];
      if (data_wr) begin
        case (st)
          ST_BASE: begin
            vec_base <= wdata;
            st <= single ? (need_mode ? ST_MODE : ST_RUN) : ST_CASC;
          end
          ST_CASC: st <= need_mode ? ST_MODE : ST_RUN;
          ST_MODE: st <= ST_RUN;
          default: mask_q <= wdata[N-1:0];
        endcase
      end
    end
  end

  // R7: an accepted acknowledge leaves the winner in service
  p_ack_sets_isr_r7: assert property (@(posedge clk) disable iff (rst)
    (take && !init_cmd) |=> isr_q[$past(win_idx)]);
  // R3: the start byte clears state and rewinds the write pointer
  p_init_clears_r3: assert property (@(posedge clk) disable iff (rst)
    init_cmd |=> (mask_q == '1 && isr_q == '0 && st == ST_BASE));
  // R9: end-of-interrupt retires exactly one in-service bit
  p_eoi_one_bit_r9: assert property (@(posedge clk) disable iff (rst)
    (eoi_cmd && isr_any && !ack && !init_cmd) |=>
      ($countones(isr_q) == $countones($past(isr_q)) - 1));
  // R4: a full mask silences the unit
  p_full_mask_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (data_wr && st == ST_RUN && wdata[N-1:0] == '1 && !cmd_wr) |=> !int_out);
endmodule

// File: rtl/pic_cascade_top.sv
module pic_cascade_top #(
  parameter int LINES     = 16,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 3,
  parameter int CASC_SLOT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [LINES-1:0]  irq_in,
  output logic              cpu_irq,
  input  logic              int_ack,
  output logic              vec_valid,
  output logic [DATA_W-1:0] vec_out
);
  localparam int UNIT_N = LINES / 2;
  localparam int IDX_W  = $clog2(UNIT_N);

  logic [UNIT_N-1:0] trig_pri, trig_sec, pri_req, pri_lvl;
  logic [UNIT_N-1:0] pri_mask, pri_irr, pri_isr, sec_mask, sec_irr, sec_isr;
  logic              pri_int, sec_int, pri_rsel, sec_rsel, sec_ack, pri_casc_win;
  logic [IDX_W-1:0]  pri_win, sec_win;
  logic [DATA_W-1:0] pri_base, sec_base;
  logic              unused_cascade_pin;

  assign unused_cascade_pin = irq_in[CASC_SLOT];

  always_comb begin
    pri_req = irq_in[UNIT_N-1:0];
    pri_req[CASC_SLOT] = sec_int;
    pri_lvl = trig_pri;
    pri_lvl[CASC_SLOT] = 1'b1;
  end

  assign pri_casc_win = pri_int && (pri_win == IDX_W'(CASC_SLOT));
  assign sec_ack      = int_ack && pri_casc_win;

  pic_unit #(.N(UNIT_N), .DW(DATA_W), .IW(IDX_W)) u_pri (
    .clk(clk), .rst(rst),
    .cmd_wr(bus_wr && bus_addr == ADDR_W'(0)),
    .data_wr(bus_wr && bus_addr == ADDR_W'(1)),
    .wdata(bus_wdata), .level_sel(pri_lvl), .req_in(pri_req), .ack(int_ack),
    .int_out(pri_int), .win_idx(pri_win), .vec_base(pri_base),
    .mask_q(pri_mask), .irr_view(pri_irr), .isr_q(pri_isr), .read_isr(pri_rsel));

  pic_unit #(.N(UNIT_N), .DW(DATA_W), .IW(IDX_W)) u_sec (
    .clk(clk), .rst(rst),
    .cmd_wr(bus_wr && bus_addr == ADDR_W'(2)),
    .data_wr(bus_wr && bus_addr == ADDR_W'(3)),
    .wdata(bus_wdata), .level_sel(trig_sec), .req_in(irq_in[LINES-1:UNIT_N]), .ack(sec_ack),
    .int_out(sec_int), .win_idx(sec_win), .vec_base(sec_base),
    .mask_q(sec_mask), .irr_view(sec_irr), .isr_q(sec_isr), .read_isr(sec_rsel));

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_pri  <= '0;
      trig_sec  <= '0;
      bus_rdata <= '0;
      cpu_irq   <= 1'b0;
      vec_valid <= 1'b0;
      vec_out   <= '0;
    end else begin
      if (bus_wr && bus_addr == ADDR_W'(4)) trig_pri <= bus_wdata[UNIT_N-1:0];
      if (bus_wr && bus_addr == ADDR_W'(5)) trig_sec <= bus_wdata[UNIT_N-1:0];
      cpu_irq   <= pri_int;
      vec_valid <= int_ack;
      if (int_ack) begin
        if (!pri_int)
          vec_out <= DATA_W'(pri_base + DATA_W'(UNIT_N - 1));
        else if (pri_casc_win)
          vec_out <= DATA_W'(sec_base + DATA_W'(sec_win));
        else
          vec_out <= DATA_W'(pri_base + DATA_W'(pri_win));
      end
      if (bus_rd) begin
        case (bus_addr)
          ADDR_W'(0): bus_rdata <= DATA_W'(pri_rsel ? pri_isr : pri_irr);
          ADDR_W'(1): bus_rdata <= DATA_W'(pri_mask);
          ADDR_W'(2): bus_rdata <= DATA_W'(sec_rsel ? sec_isr : sec_irr);
          ADDR_W'(3): bus_rdata <= DATA_W'(sec_mask);
          ADDR_W'(4): bus_rdata <= DATA_W'(trig_pri);
          ADDR_W'(5): bus_rdata <= DATA_W'(trig_sec);
          default:    bus_rdata <= '0;
        endcase
      end
    end
  end

  // R7: a secondary winner marks both units in service
  p_cascade_both_r7: assert property (@(posedge clk) disable iff (rst)
    (int_ack && pri_casc_win && !bus_wr) |=> (pri_isr[CASC_SLOT] && sec_isr != '0));
  // R11: an acknowledge with nothing qualifying leaves in-service bits alone
  p_spurious_keeps_isr_r11: assert property (@(posedge clk) disable iff (rst)
    (int_ack && !pri_int && !bus_wr) |=> $stable(pri_isr));
endmodule

// File: tb/pic_cascade_top_tb_top.sv
module pic_cascade_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, int_ack = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [15:0] irq_in = '0;
  logic [7:0]  bus_rdata, vec_out;
  logic        cpu_irq, vec_valid;
  int          checks = 0, errors = 0;
  logic [7:0]  rv;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pic_cascade_top dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in), .cpu_irq(cpu_irq),
    .int_ack(int_ack), .vec_valid(vec_valid), .vec_out(vec_out));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic do_ack(output logic [7:0] v, output logic ok);
    @(negedge clk); int_ack = 1'b1;
    @(negedge clk); int_ack = 1'b0; v = vec_out; ok = vec_valid;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  // Expected {request found, vector} from the fifteen-line order, bases 0x20 / 0x28
  function automatic logic [8:0] exp_vec(input logic [15:0] rq, input logic [7:0] pm,
                                         input logic [7:0] sm);
    logic [7:0] sp, pp;
    sp = rq[15:8] & ~sm;
    pp = {rq[7:3], |sp, rq[1:0]} & ~pm;
    for (int k = 0; k < 15; k++) begin
      int ln;
      ln = (k < 2) ? k : ((k < 10) ? k + 6 : k - 7);
      if (ln < 8 ? pp[ln] : (pp[2] && sp[ln-8])) return {1'b1, 8'(8'h20 + ln)};
    end
    return {1'b0, 8'h27};
  endfunction

  task automatic init_std();
    wr(0, 8'h11); wr(1, 8'h20); wr(1, 8'h04); wr(1, 8'h01);
    wr(2, 8'h11); wr(3, 8'h28); wr(3, 8'h02); wr(3, 8'h01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic ok;
    logic [8:0] e;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 reset cpu_irq", cpu_irq, 0);
    chk("R7 reset vec_valid", vec_valid, 0);
    rd(1, rv); chk("R3 reset mask", rv, 8'hFF);
    rd(0, rv); chk("R10 reset IRR read", rv, 8'h00);
    rd(4, rv); chk("R12 reset trigger select", rv, 8'h00);

    init_std();
    // R5 and R4: edge latched while masked
    irq_in[0] = 1'b1; settle();
    chk("R4 masked line quiet", cpu_irq, 0);
    rd(0, rv); chk("R10 IRR shows latched edge", rv, 8'h01);
    wr(1, 8'hFA);
    rd(1, rv); chk("R4 mask readback", rv, 8'hFA);
    settle(); chk("R5 unmasked edge raises irq", cpu_irq, 1);
    irq_in[0] = 1'b0; settle();
    chk("R5 edge stays latched after pin falls", cpu_irq, 1);
    do_ack(v, ok);
    chk("R7 vec_valid", ok, 1);
    chk("R2 vector line 0", v, 8'h20);
    wr(0, 8'h0B); rd(0, rv); chk("R10 ISR read", rv, 8'h01);
    settle(); chk("R5 acknowledge clears latch", cpu_irq, 0);
    wr(0, 8'h20); rd(0, rv); chk("R9 EOI clears ISR", rv, 8'h00);

    // R6: level line 5
    wr(4, 8'h20); rd(4, rv); chk("R12 trigger readback", rv, 8'h20);
    wr(1, 8'h00);
    irq_in[5] = 1'b1; settle(); chk("R6 level raises irq", cpu_irq, 1);
    irq_in[5] = 1'b0; settle(); chk("R6 level drop clears irq", cpu_irq, 0);
    do_ack(v, ok); chk("R11 spurious vector", v, 8'h27);
    rd(0, rv); chk("R11 spurious leaves ISR", rv, 8'h00);

    // R8 nesting with lines 5 (level), 3 and 6 (edge)
    irq_in[5] = 1'b1; settle();
    do_ack(v, ok); chk("R7 vector line 5", v, 8'h25);
    settle(); chk("R8 same line blocked", cpu_irq, 0);
    irq_in[3] = 1'b1; settle(); chk("R8 higher line passes", cpu_irq, 1);
    do_ack(v, ok); chk("R8 nested vector line 3", v, 8'h23);
    irq_in[6] = 1'b1; settle(); chk("R8 lower line blocked", cpu_irq, 0);
    rd(0, rv); chk("R7 ISR holds 3 and 5", rv, 8'h28);
    wr(0, 8'h20); rd(0, rv); chk("R9 EOI takes highest", rv, 8'h20);
    chk("R8 still blocked by 5", cpu_irq, 0);
    wr(0, 8'h20); settle(); chk("R8 released after EOI", cpu_irq, 1);
    do_ack(v, ok); chk("R1 5 before 6", v, 8'h25);
    irq_in[5] = 1'b0; wr(0, 8'h20); settle();
    do_ack(v, ok); chk("R5 latched 6 served", v, 8'h26);
    wr(0, 8'h20); irq_in[3] = 1'b0; irq_in[6] = 1'b0;

    // R1 and R7 cascade: line 9 against line 4
    wr(5, 8'hFF); wr(3, 8'h00);
    rd(5, rv); chk("R12 secondary trigger readback", rv, 8'hFF);
    irq_in[9] = 1'b1; irq_in[4] = 1'b1; settle();
    do_ack(v, ok); chk("R1 line 9 beats line 4", v, 8'h29);
    rd(0, rv); chk("R7 primary bit 2 in service", rv, 8'h04);
    wr(2, 8'h0B); rd(2, rv); chk("R7 secondary bit in service", rv, 8'h02);
    settle(); chk("R8 line 4 below cascade slot", cpu_irq, 0);
    irq_in[9] = 1'b0; wr(2, 8'h20); wr(0, 8'h20); settle();
    chk("R8 line 4 released", cpu_irq, 1);
    do_ack(v, ok); chk("R2 vector line 4", v, 8'h24);
    wr(0, 8'h20); irq_in[4] = 1'b0;

    // R3 re-init in single mode with new base, in-service state pending
    irq_in[1] = 1'b1; settle();
    do_ack(v, ok); chk("R2 vector line 1", v, 8'h21);
    wr(0, 8'h13); wr(1, 8'h40); wr(1, 8'h01); wr(1, 8'h00);
    rd(1, rv); chk("R3 cascade byte skipped", rv, 8'h00);
    wr(0, 8'h0B); rd(0, rv); chk("R3 init cleared ISR", rv, 8'h00);
    irq_in[6] = 1'b1; settle();
    do_ack(v, ok); chk("R2 new base", v, 8'h46);
    wr(0, 8'h20); irq_in = '0;
    wr(0, 8'h11); wr(1, 8'h20); wr(1, 8'h04); wr(1, 8'h01);

    // Random level-triggered rounds
    wr(4, 8'hFF); wr(5, 8'hFF);
    for (int r = 0; r < 60; r++) begin
      logic [15:0] rq;
      logic [7:0] pm, sm;
      rq = 16'($urandom);
      pm = (r % 4 == 0) ? 8'(($urandom % 2) ? 8'h00 : 8'hFF) : 8'($urandom);
      sm = 8'($urandom);
      wr(1, pm); wr(3, sm);
      irq_in = rq; settle();
      e = exp_vec(rq, pm, sm);
      chk("R1 random cpu_irq", cpu_irq, e[8]);
      do_ack(v, ok);
      chk("R1 random vector", v, e[7:0]);
      irq_in = '0;
      if (e[8]) begin
        if (e[7:0] >= 8'h28) wr(2, 8'h20);
        wr(0, 8'h20);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule